// File: doc/BRIEF.md
# Power-of-Two Clock Prescaler with Glitch-Free Gating

This block takes a fast reference clock and produces a slower output clock whose half-period is a programmable power of two of reference cycles. The reference clock is modelled at twice the rate of the oscillator it stands for, so a setting of x divides that oscillator by 2^x. The output is a register, so it never carries combinational glitches. An output-enable input starts and stops it. Starting and stopping happen only at phase boundaries, so every high pulse has full width.

Two more controls decide whether the output may run. A startup qualifier keeps the block not-ready for a fixed number of reference cycles after reset. A power-down input must stay asserted for a minimum run of cycles before it is accepted. Once accepted, it stops the divider at once. When power-down is released, the startup qualification runs again from the start.

Top module: `clk_prescale_gate`

## Requirements
- R1: After reset is released, `ready` is low for the first 511 rising edges of `clk` and goes high on edge 512 (QUAL_CYCLES).
- R2: `clk_out` stays low whenever `ready` is low, whatever `oe` does.
- R3: While the output runs with setting x, each high phase and each low phase of `clk_out` lasts exactly 2^x cycles of `clk`.
- R4: A `prescale` value above 8 (MAX_EXP) behaves exactly like 8.
- R5: From idle, `oe` is taken at the first `clk` edge where `oe` and `ready` are both high. The output is low at that moment, and its first transition is a rise exactly 2^x edges later.
- R6: When `oe` drops during a high phase, that high phase still lasts its full 2^x cycles. The output then stays low.
- R7: A high pulse on `pdn` lasting fewer than DEGLITCH_CYCLES + 2^(x+2) consecutive edges has no effect, and `ready` stays high.
- R8: When `pdn` stays high for DEGLITCH_CYCLES + 2^(x+2) consecutive edges, `clk_out` is low from the last of those edges onward. `ready` is low from the following edge.
- R9: After `pdn` falls, `ready` returns high 512 edges after the first edge that samples `pdn` low.
- R10: A change of `prescale` while the output runs takes effect at the next falling edge of `clk_out`. The high phase in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the modelled oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale | input | 4 | Division exponent x; values above 8 act as 8 |
| oe | input | 1 | Output enable request |
| pdn | input | 1 | Power-down request, active high |
| clk_out | output | 1 | Gated divided clock |
| ready | output | 1 | High once startup qualification has completed |

## Verification
Two functions can land on the same edge. Power-down may be accepted while the divided output is high, and the end of qualification may coincide with a pending enable request. The bench holds `pdn` through the exact acceptance count while the output runs with x = 2, and checks that `clk_out` drops on the accepting edge and `ready` one edge later. It also holds `oe` high from reset, so that the first rise is expected exactly two edges after `ready` rises. An expectation queue catches any stray or missing transition.

// File: rtl/clk_prescale_gate.sv
module clk_prescale_gate #(
  parameter int SEL_W           = 4,
  parameter int MAX_EXP         = 8,
  parameter int QUAL_CYCLES     = 512,
  parameter int DEGLITCH_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] prescale,
  input  logic             oe,
  input  logic             pdn,
  output logic             clk_out,
  output logic             ready
);

  localparam int HC_W = (MAX_EXP > 0) ? MAX_EXP + 1 : 2;
  localparam int XW   = $clog2(MAX_EXP + 1) + 1;
  localparam int QW   = $clog2(QUAL_CYCLES + 1);
  localparam int PW   = $clog2(DEGLITCH_CYCLES + (4 << MAX_EXP) + 1) + 1;

  logic [HC_W-1:0] hc;
  logic [XW-1:0]   xs;
  logic [QW-1:0]   qcnt;
  logic [PW-1:0]   pcnt;
  logic            div_ph, gate, pd_active;

  wire [XW-1:0]   sel_c  = (prescale > SEL_W'(MAX_EXP)) ? XW'(MAX_EXP) : XW'(prescale);
  wire [HC_W-1:0] last   = (HC_W'(1) << xs) - HC_W'(1);
  wire [PW-1:0]   thr    = PW'(DEGLITCH_CYCLES) + (PW'(4) << xs);
  wire            pd_hit = pdn && !pd_active && (pcnt == thr - PW'(1));
  wire            en_req = oe && ready && !pd_active;

  assign clk_out = div_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt  <= '0;
      ready <= 1'b0;
    end else if (pd_active) begin
      qcnt  <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      qcnt <= qcnt + QW'(1);
      if (qcnt == QW'(QUAL_CYCLES - 1)) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      pd_active <= 1'b0;
    end else if (!pdn) begin
      pcnt      <= '0;
      pd_active <= 1'b0;
    end else if (!pd_active) begin
      if (pd_hit) begin
        pd_active <= 1'b1;
        pcnt      <= '0;
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc     <= '0;
      div_ph <= 1'b0;
      gate   <= 1'b0;
      xs     <= '0;
    end else if (pd_hit || pd_active) begin
      hc     <= '0;
      div_ph <= 1'b0;
      gate   <= 1'b0;
      xs     <= sel_c;
    end else if (!gate) begin
      hc     <= '0;
      div_ph <= 1'b0;
      xs     <= sel_c;
      gate   <= en_req;
    end else if (hc == last) begin
      hc     <= '0;
      div_ph <= ~div_ph;
      if (div_ph) begin
        xs <= sel_c;
        if (!en_req) gate <= 1'b0;
      end
    end else begin
      hc <= hc + HC_W'(1);
    end
  end

  logic [HC_W:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (clk_out) hi_run <= hi_run + (HC_W+1)'(1);
    else              hi_run <= '0;
  end

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xs <= XW'(MAX_EXP));

  assert_quiet_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !clk_out);

  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> !clk_out);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_out) && !pd_active) |-> (hi_run == ((HC_W+1)'(1) << $past(xs))));

  assert_pd_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !clk_out);

  assert_pd_unready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |=> !ready);

endmodule

// File: tb/sim_clk_prescale_gate.sv
module sim_clk_prescale_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] prescale = 4'd0;
  logic       oe = 1'b0;
  logic       pdn = 1'b0;
  logic       clk_out, ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit prev_out = 1'b0;
  int q_cyc[$];
  bit q_lvl[$];

  always #4 clk = ~clk;

  clk_prescale_gate u0 (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .oe(oe), .pdn(pdn),
    .clk_out(clk_out), .ready(ready)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected transitions as clk_out changes
  always @(negedge clk) begin
    if (rst_n && clk_out != prev_out && mon_on) begin
      if (q_cyc.size() == 0) begin
        chk(1'b0, "R3/R6 unexpected edge", cyc, -1);
      end else begin
        int ec;
        bit el;
        ec = q_cyc.pop_front();
        el = q_lvl.pop_front();
        chk(ec == cyc && el == clk_out, "R3/R5 edge time", cyc, ec);
      end
    end
    prev_out = clk_out;
  end

  task automatic push(int c, bit l);
    q_cyc.push_back(c);
    q_lvl.push_back(l);
  endtask

  // driver: enable with setting x (effective xe), expect n pulses, drop oe in last high phase
  task automatic run_pulses(int x, int xe, int n, string req);
    int s, h;
    @(negedge clk);
    prescale = 4'(x);
    oe = 1'b1;
    s = cyc + 1;
    h = 1 << xe;
    for (int k = 0; k < n; k++) begin
      push(s + h * (2 * k + 1), 1'b1);
      push(s + h * (2 * k + 2), 1'b0);
    end
    while (cyc < s + h * (2 * n - 1)) @(negedge clk);
    oe = 1'b0;
    repeat (3 * h + 4) @(negedge clk);
    chk(q_cyc.size() == 0, req, q_cyc.size(), 0);
    chk(clk_out == 1'b0, "R6 idle low after oe drop", clk_out, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, s, d;
    oe = 1'b1;
    prescale = 4'd0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 reset ready", ready, 0);
    chk(clk_out == 1'b0, "R2 reset output", clk_out, 0);
    rst_n = 1'b1;
    // R1 / R2 with oe already high
    while (cyc < 100) @(negedge clk);
    chk(clk_out == 1'b0, "R2 low during qualification", clk_out, 0);
    while (cyc < 511) @(negedge clk);
    chk(ready == 1'b0, "R1 not ready at 511", ready, 0);
    chk(clk_out == 1'b0, "R2 low at 511", clk_out, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready at 512", ready, 1);
    @(negedge clk);
    chk(clk_out == 1'b0, "R5 still low at 513", clk_out, 0);
    @(negedge clk);
    chk(clk_out == 1'b1, "R5 first rise at 514", clk_out, 1);
    oe = 1'b0;
    repeat (10) @(negedge clk);
    chk(clk_out == 1'b0, "R6 stopped", clk_out, 0);
    mon_on = 1'b1;

    run_pulses(0, 0, 4, "R3 x=0 pulses");
    run_pulses(3, 3, 3, "R3 R5 x=3 pulses");
    run_pulses(1, 1, 2, "R5 x=1 latency");
    run_pulses(12, 8, 2, "R4 clamp 12 to 8");

    // R10: change setting during a high phase
    @(negedge clk);
    prescale = 4'd1;
    oe = 1'b1;
    s = cyc + 1;
    push(s + 2, 1'b1);
    push(s + 4, 1'b0);
    push(s + 8, 1'b1);
    push(s + 12, 1'b0);
    while (cyc < s + 2) @(negedge clk);
    prescale = 4'd2;
    while (cyc < s + 8) @(negedge clk);
    oe = 1'b0;
    repeat (20) @(negedge clk);
    chk(q_cyc.size() == 0, "R10 setting change at fall", q_cyc.size(), 0);

    // R7: short pdn pulse, idle x=0, threshold 24
    prescale = 4'd0;
    @(negedge clk);
    repeat (23) begin
      pdn = 1'b1;
      @(negedge clk);
    end
    pdn = 1'b0;
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R7 short pdn ignored", ready, 1);
    run_pulses(0, 0, 2, "R7 output still runs");

    // R8: accepted power-down while running x=2, threshold 36
    mon_on = 1'b0;
    @(negedge clk);
    prescale = 4'd2;
    oe = 1'b1;
    repeat (7) @(negedge clk);
    pdn = 1'b1;
    c = cyc;
    while (cyc < c + 35) @(negedge clk);
    chk(ready == 1'b1, "R8 ready before acceptance", ready, 1);
    @(negedge clk);
    chk(clk_out == 1'b0, "R8 output low on acceptance", clk_out, 0);
    @(negedge clk);
    chk(ready == 1'b0, "R8 ready low after acceptance", ready, 0);
    begin
      int bad;
      bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (clk_out) bad++;
      end
      chk(bad == 0, "R8 output held low", bad, 0);
    end
    oe = 1'b0;
    pdn = 1'b0;
    d = cyc;
    while (cyc < d + 512) @(negedge clk);
    chk(ready == 1'b0, "R9 requalify not ready", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready again", ready, 1);
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    run_pulses(2, 2, 2, "R9 output after requalify");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule